// File: doc/BRIEF.md
# System-Bus Address Parity Checker

This block sits beside one agent on a shared, multi-agent processor bus where every pin is active-low and everything moves on the rising edge of one bus clock. When its own agent launches a request, the block produces the two address parity pins so they can go out in the same clock as the address strobe and address. It also watches every request on the bus, its own included, and checks both parity pins against the address pins it sampled. If either group is wrong, it pulls the shared address-parity-error line low for one clock. This is an open-drain style drive that only ever enables a low.

The parity pins split the address into two groups of unequal size. The upper pin covers address pins 35 to 24. The lower pin covers address pins 23 to 3. A pin is correct when its level is high for an even count of low covered pins and low for an odd count. An error is valid only when it is sampled exactly two clocks after a strobe. A strap sampled while reset is held picks what a valid error does. With the strap high, the error aborts the transaction. With the strap low, the error is only flagged to a machine-check output.

Top module: `apchk_top`

## Requirements
- R1: After a rising edge that samples `iss_req` high, `out_ap_oe` is 1 for that one clock. In the same clock, `out_ap_n[1]` is high exactly when an even number of `iss_a_n[35:24]` are low, and `out_ap_n[0]` is high exactly when an even number of `iss_a_n[23:3]` are low.
- R2: A strobe sampled with both parity pins correct by the rule in R1 never raises `aerr_oe`.
- R3: The two groups are checked independently. A wrong upper pin, a wrong lower pin, or both wrong raises `aerr_oe`.
- R4: If `bus_ads_n` is sampled low at edge k with bad parity, `aerr_oe` is 1 from edge k+1 to edge k+2 and 0 after that. `aerr_oe` is never 1 unless a strobe was sampled two edges earlier.
- R5: Strobes on consecutive clocks are each checked in their own slot, with no interference between them.
- R6: Address and parity pins sampled while `bus_ads_n` is high are ignored.
- R7: `cfg_abort_strap` is captured on edges where `rst_n` is low. After release, changes to the strap have no effect.
- R8: With the captured strap at 1, a low `bus_aerr_n` sampled at edge k+2 after a strobe at edge k makes `xact_abort` 1 for the one clock after edge k+2, while `mce_report` stays 0. This holds whichever agent drove the error.
- R9: With the captured strap at 0, the same condition makes `mce_report` 1 for one clock, while `xact_abort` stays 0.
- R10: A low `bus_aerr_n` outside a valid slot (no strobe two edges earlier) changes neither `xact_abort` nor `mce_report`.
- R11: On edges where `rst_n` is low, the block clears `aerr_oe`, `out_ap_oe`, `xact_abort` and `mce_report` to 0 and sets `out_ap_n` to 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_abort_strap | input | 1 | Power-on strap: 1 = abort on error, 0 = report only |
| iss_req | input | 1 | Own agent drives a request strobe at this edge |
| iss_a_n | input | 33 | Active-low address pins [35:3] the own agent is launching |
| out_ap_n | output | 2 | Generated parity pins, [1] upper group, [0] lower group |
| out_ap_oe | output | 1 | Drive enable for the generated parity pins |
| bus_ads_n | input | 1 | Observed address strobe, active low |
| bus_a_n | input | 33 | Observed active-low address pins [35:3] |
| bus_ap_n | input | 2 | Observed parity pins, [1] upper, [0] lower |
| bus_aerr_n | input | 1 | Observed shared address-parity-error line |
| aerr_oe | output | 1 | Pull-down enable for the shared error line |
| xact_abort | output | 1 | One-clock abort of the current transaction |
| mce_report | output | 1 | One-clock machine-check report |

## Verification
A stale or corrupted sample register would show up at `aerr_oe` exactly one clock after the strobe edge. It would appear as a wrong error pulse for that strobe, or as an error carried into a neighbouring strobe when strobes come back-to-back. A slot tracker that is one stage off would put `xact_abort` or `mce_report` one clock early or late. It would also let an error outside the slot count, which the checks at fixed offsets after each strobe catch at once. A wrongly captured strap does not show until the first valid error. At that point the wrong one of the two outputs fires, so the strap cases each end with a bad strobe.

// File: rtl/apchk_pkg.sv
package apchk_pkg;

    localparam int unsigned ADDR_MSB  = 35;
    localparam int unsigned ADDR_LSB  = 3;
    localparam int unsigned SPLIT_LSB = 24;
    localparam int unsigned NGRP      = 2;
    localparam int unsigned AW        = ADDR_MSB - ADDR_LSB + 1;

    typedef logic [ADDR_MSB:ADDR_LSB] addr_pins_t;
    typedef logic [NGRP-1:0]          par_pins_t;

    // group 1 = upper slice, group 0 = lower slice
    function automatic int unsigned grp_msb(input int unsigned g);
        return (g == 0) ? SPLIT_LSB - 1 : ADDR_MSB;
    endfunction

    function automatic int unsigned grp_lsb(input int unsigned g);
        return (g == 0) ? ADDR_LSB : SPLIT_LSB;
    endfunction

    typedef struct packed {
        logic      oe;
        par_pins_t ap_n;
    } iss_st_t;

    typedef struct packed {
        logic       s1_vld;
        addr_pins_t s1_a_n;
        par_pins_t  s1_ap_n;
        logic       oe;
        logic       slot;
    } chk_st_t;

    typedef struct packed {
        logic abort_en;
        logic abort;
        logic mce;
    } obs_st_t;

endpackage

// File: rtl/apchk_grp_par.sv
module apchk_grp_par #(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0] pins_n,
    output logic         good_level
);
    // Electrical level a correct parity pin must show: high when the count
    // of low covered pins is even.
    logic [W-1:0] lows;

    always_comb begin
        lows       = ~pins_n;
        good_level = ~(^lows);
    end
endmodule

// File: rtl/apchk_par_bank.sv
module apchk_par_bank
    import apchk_pkg::*;
(
    input  addr_pins_t a_n,
    output par_pins_t  good
);
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int unsigned HI = grp_msb(g);
        localparam int unsigned LO = grp_lsb(g);
        apchk_grp_par #(.W(HI - LO + 1)) u_par (
            .pins_n     (a_n[HI:LO]),
            .good_level (good[g])
        );
    end
endmodule

// File: rtl/apchk_issue.sv
module apchk_issue
    import apchk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       iss_req,
    input  addr_pins_t iss_a_n,
    output par_pins_t  out_ap_n,
    output logic       out_ap_oe
);
    localparam iss_st_t ISS_RST = '{oe: 1'b0, ap_n: '1};

    iss_st_t   st_d, st_q;
    par_pins_t gen_level;

    apchk_par_bank u_bank (
        .a_n  (iss_a_n),
        .good (gen_level)
    );

    always_comb begin
        st_d      = st_q;
        st_d.oe   = iss_req;
        st_d.ap_n = iss_req ? gen_level : '1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ISS_RST;
        else        st_q <= st_d;
    end

    assign out_ap_n  = st_q.ap_n;
    assign out_ap_oe = st_q.oe;
endmodule

// File: rtl/apchk_check.sv
module apchk_check
    import apchk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ads_n,
    input  addr_pins_t a_n,
    input  par_pins_t  ap_n,
    output logic       aerr_oe,
    output logic       slot
);
    localparam chk_st_t CHK_RST = '{
        s1_vld: 1'b0, s1_a_n: '1, s1_ap_n: '1, oe: 1'b0, slot: 1'b0
    };

    chk_st_t   st_d, st_q;
    par_pins_t want_level;
    par_pins_t grp_bad;

    apchk_par_bank u_bank (
        .a_n  (st_q.s1_a_n),
        .good (want_level)
    );

    always_comb begin
        st_d    = st_q;
        grp_bad = st_q.s1_ap_n ^ want_level;

        // stage 1: capture the request on a strobe
        st_d.s1_vld = ~ads_n;
        if (!ads_n) begin
            st_d.s1_a_n  = a_n;
            st_d.s1_ap_n = ap_n;
        end

        // stage 2: drive the error slot and mark it for observation
        st_d.oe   = st_q.s1_vld & (|grp_bad);
        st_d.slot = st_q.s1_vld;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CHK_RST;
        else        st_q <= st_d;
    end

    assign aerr_oe = st_q.oe;
    assign slot    = st_q.slot;
endmodule

// File: rtl/apchk_obs.sv
module apchk_obs (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_abort_strap,
    input  logic slot,
    input  logic aerr_n,
    output logic xact_abort,
    output logic mce_report
);
    import apchk_pkg::*;

    obs_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        st_d       = st_q;
        hit        = slot & ~aerr_n;
        st_d.abort = hit &  st_q.abort_en;
        st_d.mce   = hit & ~st_q.abort_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.abort_en <= cfg_abort_strap;
            st_q.abort    <= 1'b0;
            st_q.mce      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign xact_abort = st_q.abort;
    assign mce_report = st_q.mce;
endmodule

// File: rtl/apchk_top.sv
module apchk_top
    import apchk_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_abort_strap,
    input  logic                      iss_req,
    input  logic [ADDR_MSB:ADDR_LSB]  iss_a_n,
    output logic [NGRP-1:0]           out_ap_n,
    output logic                      out_ap_oe,
    input  logic                      bus_ads_n,
    input  logic [ADDR_MSB:ADDR_LSB]  bus_a_n,
    input  logic [NGRP-1:0]           bus_ap_n,
    input  logic                      bus_aerr_n,
    output logic                      aerr_oe,
    output logic                      xact_abort,
    output logic                      mce_report
);
    logic err_slot;

    apchk_issue u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_req   (iss_req),
        .iss_a_n   (iss_a_n),
        .out_ap_n  (out_ap_n),
        .out_ap_oe (out_ap_oe)
    );

    apchk_check u_check (
        .clk     (clk),
        .rst_n   (rst_n),
        .ads_n   (bus_ads_n),
        .a_n     (bus_a_n),
        .ap_n    (bus_ap_n),
        .aerr_oe (aerr_oe),
        .slot    (err_slot)
    );

    apchk_obs u_obs (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_abort_strap (cfg_abort_strap),
        .slot            (err_slot),
        .aerr_n          (bus_aerr_n),
        .xact_abort      (xact_abort),
        .mce_report      (mce_report)
    );
endmodule

// File: rtl/apchk_sva.sv
module apchk_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       iss_req,
    input logic       out_ap_oe,
    input logic       bus_ads_n,
    input logic       bus_aerr_n,
    input logic       aerr_oe,
    input logic       xact_abort,
    input logic       mce_report
);
    p_ap_oe_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_ap_oe |-> $past(iss_req));

    p_aerr_needs_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        aerr_oe |-> $past(!bus_ads_n, 2));

    p_abort_in_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xact_abort |-> ($past(!bus_aerr_n) && $past(!bus_ads_n, 3)));

    p_mce_in_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mce_report |-> ($past(!bus_aerr_n) && $past(!bus_ads_n, 3)));

    p_abort_mce_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(xact_abort && mce_report));
endmodule

bind apchk_top apchk_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_req    (iss_req),
    .out_ap_oe  (out_ap_oe),
    .bus_ads_n  (bus_ads_n),
    .bus_aerr_n (bus_aerr_n),
    .aerr_oe    (aerr_oe),
    .xact_abort (xact_abort),
    .mce_report (mce_report)
);

// File: tb/sim_apchk_top.sv
module sim_apchk_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg = 1'b1;
    logic        iss_req = 1'b0;
    logic [35:3] iss_a_n = '1;
    logic [1:0]  out_ap_n;
    logic        out_ap_oe;
    logic        ads_n = 1'b1;
    logic [35:3] a_n = '1;
    logic [1:0]  ap_n = '1;
    logic        ext_aerr = 1'b0;
    logic        bus_aerr_n;
    logic        aerr_oe;
    logic        xact_abort;
    logic        mce_report;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign bus_aerr_n = ~(aerr_oe | ext_aerr);

    apchk_top u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_abort_strap (cfg),
        .iss_req         (iss_req),
        .iss_a_n         (iss_a_n),
        .out_ap_n        (out_ap_n),
        .out_ap_oe       (out_ap_oe),
        .bus_ads_n       (ads_n),
        .bus_a_n         (a_n),
        .bus_ap_n        (ap_n),
        .bus_aerr_n      (bus_aerr_n),
        .aerr_oe         (aerr_oe),
        .xact_abort      (xact_abort),
        .mce_report      (mce_report)
    );

    // {flip[1:0], expect_err, addr_pins[35:3]}
    localparam logic [35:0] VEC [8] = '{
        {2'b00, 1'b0, 33'h1_FFFF_FFFF},
        {2'b00, 1'b0, 33'h0_0000_0000},
        {2'b01, 1'b1, 33'h1_0000_0000},
        {2'b10, 1'b1, 33'h0_1234_5678},
        {2'b11, 1'b1, 33'h1_8000_0001},
        {2'b00, 1'b0, 33'h0_00AB_CDEF},
        {2'b10, 1'b1, 33'h1_2345_6789},
        {2'b00, 1'b0, 33'h0_FFF0_0000}
    };

    function automatic logic [1:0] exp_ap(input logic [35:3] a);
        int lo = 0;
        int hi = 0;
        for (int i = 3; i <= 23; i++) if (!a[i]) lo++;
        for (int i = 24; i <= 35; i++) if (!a[i]) hi++;
        return {hi % 2 == 0, lo % 2 == 0};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic [35:3] a, input logic [1:0] flip);
        ads_n = 1'b0;
        a_n   = a;
        ap_n  = exp_ap(a) ^ flip;
    endtask

    task automatic do_reset(input logic strap);
        rst_n = 1'b0;
        cfg   = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        rst_n = 1'b0;
        cfg   = 1'b1;
        ads_n = 1'b0;
        iss_req = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 aerr_oe", {7'b0, aerr_oe}, 8'd0);
        chk("R11 ap_oe", {7'b0, out_ap_oe}, 8'd0);
        chk("R11 ap_n", {6'b0, out_ap_n}, 8'd3);
        chk("R11 abort", {7'b0, xact_abort}, 8'd0);
        chk("R11 mce", {7'b0, mce_report}, 8'd0);
        ads_n = 1'b1;
        iss_req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R1 generation, R2/R3 checking, R4 width, R8 abort
        for (int i = 0; i < 8; i++) begin
            logic [32:0] a;
            logic [1:0]  fl;
            logic        ex;
            {fl, ex, a} = VEC[i];
            strobe(a, fl);
            iss_req = 1'b1;
            iss_a_n = a;
            @(negedge clk);
            ads_n = 1'b1;
            iss_req = 1'b0;
            chk("R1 ap_oe", {7'b0, out_ap_oe}, 8'd1);
            chk("R1 ap_n", {6'b0, out_ap_n}, {6'b0, exp_ap(a)});
            @(negedge clk);
            chk("R2/R3 aerr_oe", {7'b0, aerr_oe}, {7'b0, ex});
            chk("R1 ap_oe one clock", {7'b0, out_ap_oe}, 8'd0);
            @(negedge clk);
            chk("R4 aerr width", {7'b0, aerr_oe}, 8'd0);
            chk("R8 abort", {7'b0, xact_abort}, {7'b0, ex});
            chk("R8 mce quiet", {7'b0, mce_report}, 8'd0);
        end
        repeat (2) @(negedge clk);

        // R6: bad parity without a strobe
        ads_n = 1'b1;
        a_n   = 33'h0_0000_0001;
        ap_n  = ~exp_ap(33'h0_0000_0001);
        @(negedge clk);
        @(negedge clk);
        chk("R6 no aerr", {7'b0, aerr_oe}, 8'd0);
        @(negedge clk);
        chk("R6 no aerr late", {7'b0, aerr_oe}, 8'd0);
        chk("R6 no abort", {7'b0, xact_abort}, 8'd0);

        // R5: bad, good, bad strobes back-to-back
        strobe(33'h1_0F0F_0F0F, 2'b01);
        @(negedge clk);
        strobe(33'h0_3333_3333, 2'b00);
        @(negedge clk);
        strobe(33'h1_5555_AAAA, 2'b10);
        chk("R5 first slot", {7'b0, aerr_oe}, 8'd1);
        @(negedge clk);
        ads_n = 1'b1;
        chk("R5 second slot", {7'b0, aerr_oe}, 8'd0);
        chk("R5 first abort", {7'b0, xact_abort}, 8'd1);
        @(negedge clk);
        chk("R5 third slot", {7'b0, aerr_oe}, 8'd1);
        chk("R5 second abort", {7'b0, xact_abort}, 8'd0);
        @(negedge clk);
        chk("R5 third abort", {7'b0, xact_abort}, 8'd1);
        chk("R4 no trailing aerr", {7'b0, aerr_oe}, 8'd0);
        repeat (2) @(negedge clk);

        // R10: external error with no strobe in its slot
        ext_aerr = 1'b1;
        @(negedge clk);
        ext_aerr = 1'b0;
        chk("R10 abort", {7'b0, xact_abort}, 8'd0);
        chk("R10 mce", {7'b0, mce_report}, 8'd0);
        @(negedge clk);
        chk("R10 abort late", {7'b0, xact_abort}, 8'd0);

        // R8: external agent errors a clean request in its slot
        strobe(33'h0_ABCD_0123, 2'b00);
        @(negedge clk);
        ads_n = 1'b1;
        @(negedge clk);
        chk("R2 own check clean", {7'b0, aerr_oe}, 8'd0);
        ext_aerr = 1'b1;
        @(negedge clk);
        ext_aerr = 1'b0;
        chk("R8 external abort", {7'b0, xact_abort}, 8'd1);
        repeat (2) @(negedge clk);

        // R7/R9: strap low at reset, raised after release
        do_reset(1'b0);
        @(negedge clk);
        cfg = 1'b1;
        strobe(33'h1_1111_1111, 2'b11);
        @(negedge clk);
        ads_n = 1'b1;
        @(negedge clk);
        chk("R9 aerr", {7'b0, aerr_oe}, 8'd1);
        @(negedge clk);
        chk("R9 mce", {7'b0, mce_report}, 8'd1);
        chk("R7 no abort after strap change", {7'b0, xact_abort}, 8'd0);
        @(negedge clk);
        chk("R9 mce one clock", {7'b0, mce_report}, 8'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule